// File: doc/BRIEF.md
# Strided two-dimensional local-memory DMA engine

This engine moves rectangular blocks of bytes between a 24-bit main memory and one of two 4 KB local memories, one holding instructions and one holding data. Software first loads a local address and a main address through a small register port, then writes one of two length registers. The choice of length register sets the direction of the copy, and that write starts the transfer.

A single 32-bit length word describes the rectangle. The low field gives the row size, always rounded up to whole 8-byte units. The middle field gives the number of rows. The top field gives a gap in bytes that is added to the main-memory address after each row. The local side walks contiguously and wraps inside the selected 4 KB memory.

Every byte address on both sides has its low two bits inverted, which turns byte order around within each 32-bit word. Each byte takes two cycles: one to read the source and one to write the destination. `busy` covers the whole transfer, and `done` pulses once at the end.

Top module: `strided_dma`

## Requirements
- R1: The length word bits 11:0 hold a field F. Each row moves (F | 7) + 1 bytes, so F=5 gives 8 bytes and F=9 gives 16 bytes.
- R2: Length word bits 19:12 hold the row count minus one.
- R3: Length word bits 31:20 hold a skip S. After each row ends, the main address advances by S in addition to its normal one-byte step. The S bytes in the gap are not touched.
- R4: Local address register bits 11:0 give the start offset. Bit 12 selects the instruction memory (1) or the data memory (0). The unselected memory is never written.
- R5: The main address register keeps only bits 23:0. Any higher bits written are ignored.
- R6: `reg_sel` codes: 0 is the local address, 1 is the main address, 2 is the length with copy main to local, 3 is the length with copy local to main.
- R7: The byte at logical offset a is found at port address a XOR 3 on both the local and main sides.
- R8: The local address increments by one per byte with no skip and wraps modulo 4096 inside the selected memory.
- R9: `busy` is high from the cycle after the length write for exactly 2 cycles per byte. `done` is high for exactly one cycle, in the first cycle `busy` is low.
- R10: A length write while `busy` is high is ignored. An address write while busy does not change the transfer in progress. A length write in the cycle `done` is high starts a new transfer.
- R11: After reset, `busy` and `done` are low and no memory write enable is asserted while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (see R6) |
| reg_wdata | input | 32 | Register write data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| imem_addr | output | 12 | Instruction memory byte address |
| imem_we | output | 1 | Instruction memory write enable |
| imem_wdata | output | 8 | Instruction memory write data |
| imem_rdata | input | 8 | Instruction memory read data, one cycle after address |
| dmem_addr | output | 12 | Data memory byte address |
| dmem_we | output | 1 | Data memory write enable |
| dmem_wdata | output | 8 | Data memory write data |
| dmem_rdata | input | 8 | Data memory read data, one cycle after address |
| mm_addr | output | 24 | Main memory byte address |
| mm_we | output | 1 | Main memory write enable |
| mm_wdata | output | 8 | Main memory write data |
| mm_rdata | input | 8 | Main memory read data, one cycle after address |

## Verification
Two events can land in one cycle: the end-of-transfer pulse and a new length write. The bench watches for `done` and drives the next length write in that same cycle. It then expects `busy` to be high at the next sample, the second block to arrive complete, and its busy time to match its own byte count. A separate scenario places address and length writes in the middle of a transfer. It then checks that the busy time, the destination bytes and the untouched other memory all match the first command alone.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {
    SEL_LOCAL   = 2'd0,
    SEL_MAIN    = 2'd1,
    SEL_LEN_IN  = 2'd2,
    SEL_LEN_OUT = 2'd3
  } reg_sel_e;

  typedef enum logic {
    DIR_IN  = 1'b0,
    DIR_OUT = 1'b1
  } dir_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_STORE = 2'd2
  } walk_st_e;

  // packed length word: gap (31:20), rows-1 (19:12), row field (11:0)
  typedef struct packed {
    logic [11:0] gap;
    logic [7:0]  rows_m1;
    logic [11:0] row_f;
  } len_word_t;
endpackage

// File: rtl/dma_cfg.sv
module dma_cfg
  import dma_pkg::*;
#(
  parameter int LOC_AW  = 12,
  parameter int MAIN_AW = 24,
  parameter int REG_W   = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_we,
  input  logic [1:0]         reg_sel,
  input  logic [REG_W-1:0]   reg_wdata,
  input  logic               busy,
  output logic               start,
  output dir_e               start_dir,
  output len_word_t          start_len,
  output logic [LOC_AW:0]    loc_q,
  output logic [MAIN_AW-1:0] main_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      loc_q  <= '0;
      main_q <= '0;
    end else if (reg_we) begin
      if (reg_sel == SEL_LOCAL) loc_q  <= reg_wdata[LOC_AW:0];
      if (reg_sel == SEL_MAIN)  main_q <= reg_wdata[MAIN_AW-1:0];
    end
  end

  assign start     = reg_we && reg_sel[1] && !busy;
  assign start_dir = reg_sel[0] ? DIR_OUT : DIR_IN;
  assign start_len = len_word_t'(reg_wdata);
endmodule

// File: rtl/dma_walk.sv
module dma_walk
  import dma_pkg::*;
#(
  parameter int LOC_AW  = 12,
  parameter int MAIN_AW = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  dir_e               start_dir,
  input  len_word_t          start_len,
  input  logic [LOC_AW:0]    start_loc,
  input  logic [MAIN_AW-1:0] start_main,
  output logic               busy,
  output logic               done,
  output dir_e               dir,
  output logic               lsel,
  output logic [LOC_AW-1:0]  laddr,
  output logic [MAIN_AW-1:0] maddr,
  output logic               store
);
  walk_st_e    st;
  len_word_t   len_q;
  logic [11:0] bcnt;
  logic [7:0]  rcnt;
  logic [11:0] row_last;
  logic        row_end;
  logic        xfer_end;

  assign row_last = len_q.row_f | 12'd7;
  assign row_end  = (bcnt == row_last);
  assign xfer_end = row_end && (rcnt == len_q.rows_m1);

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      done  <= 1'b0;
      len_q <= '0;
      bcnt  <= '0;
      rcnt  <= '0;
      dir   <= DIR_IN;
      lsel  <= 1'b0;
      laddr <= '0;
      maddr <= '0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: if (start) begin
          st    <= ST_FETCH;
          len_q <= start_len;
          dir   <= start_dir;
          lsel  <= start_loc[LOC_AW];
          laddr <= start_loc[LOC_AW-1:0];
          maddr <= start_main;
          bcnt  <= '0;
          rcnt  <= '0;
        end
        ST_FETCH: st <= ST_STORE;
        ST_STORE: begin
          laddr <= laddr + 1'b1;
          if (row_end) begin
            bcnt  <= '0;
            maddr <= maddr + MAIN_AW'(1) + MAIN_AW'(len_q.gap);
            rcnt  <= rcnt + 1'b1;
          end else begin
            bcnt  <= bcnt + 1'b1;
            maddr <= maddr + 1'b1;
          end
          if (xfer_end) begin
            st   <= ST_IDLE;
            done <= 1'b1;
          end else begin
            st <= ST_FETCH;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy  = (st != ST_IDLE);
  assign store = (st == ST_STORE);
endmodule

// File: rtl/dma_route.sv
module dma_route
  import dma_pkg::*;
#(
  parameter int LOC_AW  = 12,
  parameter int MAIN_AW = 24,
  parameter int DW      = 8,
  parameter int SWZ     = 3
) (
  input  dir_e               dir,
  input  logic               lsel,
  input  logic               store,
  input  logic [LOC_AW-1:0]  laddr,
  input  logic [MAIN_AW-1:0] maddr,
  output logic [LOC_AW-1:0]  imem_addr,
  output logic               imem_we,
  output logic [DW-1:0]      imem_wdata,
  input  logic [DW-1:0]      imem_rdata,
  output logic [LOC_AW-1:0]  dmem_addr,
  output logic               dmem_we,
  output logic [DW-1:0]      dmem_wdata,
  input  logic [DW-1:0]      dmem_rdata,
  output logic [MAIN_AW-1:0] mm_addr,
  output logic               mm_we,
  output logic [DW-1:0]      mm_wdata,
  input  logic [DW-1:0]      mm_rdata
);
  logic [LOC_AW-1:0] lphys;
  logic [DW-1:0]     loc_rd;

  assign lphys      = laddr ^ LOC_AW'(SWZ);
  assign imem_addr  = lphys;
  assign dmem_addr  = lphys;
  assign mm_addr    = maddr ^ MAIN_AW'(SWZ);
  assign loc_rd     = lsel ? imem_rdata : dmem_rdata;
  assign imem_wdata = mm_rdata;
  assign dmem_wdata = mm_rdata;
  assign mm_wdata   = loc_rd;
  assign imem_we    = store && (dir == DIR_IN) && lsel;
  assign dmem_we    = store && (dir == DIR_IN) && !lsel;
  assign mm_we      = store && (dir == DIR_OUT);
endmodule

// File: rtl/strided_dma.sv
module strided_dma
  import dma_pkg::*;
#(
  parameter int LOC_AW  = 12,
  parameter int MAIN_AW = 24,
  parameter int REG_W   = 32,
  parameter int DW      = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_we,
  input  logic [1:0]         reg_sel,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic               busy,
  output logic               done,
  output logic [LOC_AW-1:0]  imem_addr,
  output logic               imem_we,
  output logic [DW-1:0]      imem_wdata,
  input  logic [DW-1:0]      imem_rdata,
  output logic [LOC_AW-1:0]  dmem_addr,
  output logic               dmem_we,
  output logic [DW-1:0]      dmem_wdata,
  input  logic [DW-1:0]      dmem_rdata,
  output logic [MAIN_AW-1:0] mm_addr,
  output logic               mm_we,
  output logic [DW-1:0]      mm_wdata,
  input  logic [DW-1:0]      mm_rdata
);
  logic               start;
  dir_e               start_dir;
  len_word_t          start_len;
  logic [LOC_AW:0]    loc_q;
  logic [MAIN_AW-1:0] main_q;
  dir_e               dir;
  logic               lsel;
  logic               store;
  logic [LOC_AW-1:0]  laddr;
  logic [MAIN_AW-1:0] maddr;

  dma_cfg #(.LOC_AW(LOC_AW), .MAIN_AW(MAIN_AW), .REG_W(REG_W)) u_cfg (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .busy(busy), .start(start),
    .start_dir(start_dir), .start_len(start_len),
    .loc_q(loc_q), .main_q(main_q)
  );

  dma_walk #(.LOC_AW(LOC_AW), .MAIN_AW(MAIN_AW)) u_walk (
    .clk(clk), .rst(rst), .start(start), .start_dir(start_dir),
    .start_len(start_len), .start_loc(loc_q), .start_main(main_q),
    .busy(busy), .done(done), .dir(dir), .lsel(lsel),
    .laddr(laddr), .maddr(maddr), .store(store)
  );

  dma_route #(.LOC_AW(LOC_AW), .MAIN_AW(MAIN_AW), .DW(DW)) u_route (
    .dir(dir), .lsel(lsel), .store(store), .laddr(laddr), .maddr(maddr),
    .imem_addr(imem_addr), .imem_we(imem_we), .imem_wdata(imem_wdata),
    .imem_rdata(imem_rdata), .dmem_addr(dmem_addr), .dmem_we(dmem_we),
    .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata), .mm_addr(mm_addr),
    .mm_we(mm_we), .mm_wdata(mm_wdata), .mm_rdata(mm_rdata)
  );
endmodule

// File: rtl/dma_check.sv
module dma_check (
  input logic       clk,
  input logic       rst,
  input logic       reg_we,
  input logic [1:0] reg_sel,
  input logic       busy,
  input logic       done,
  input logic       imem_we,
  input logic       dmem_we,
  input logic       mm_we
);
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_after_busy_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  p_busy_from_len_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(reg_we && reg_sel[1]));

  p_writes_alternate_r9: assert property (@(posedge clk) disable iff (rst)
    (imem_we || dmem_we || mm_we) |=> !(imem_we || dmem_we || mm_we));

  p_one_target_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({imem_we, dmem_we, mm_we}));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !(imem_we || dmem_we || mm_we));
endmodule

bind strided_dma dma_check u_chk (.*);

// File: tb/sim_strided_dma.sv
module sim_strided_dma;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic        busy, done;
  logic [11:0] imem_addr, dmem_addr;
  logic        imem_we, dmem_we, mm_we;
  logic [7:0]  imem_wdata, dmem_wdata, mm_wdata;
  logic [7:0]  imem_rdata, dmem_rdata, mm_rdata;
  logic [23:0] mm_addr;

  logic [7:0] imem [0:4095];
  logic [7:0] dmem [0:4095];
  logic [7:0] mmem [0:65535];

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #10 clk = ~clk;

  strided_dma u0 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .busy(busy), .done(done),
    .imem_addr(imem_addr), .imem_we(imem_we), .imem_wdata(imem_wdata),
    .imem_rdata(imem_rdata), .dmem_addr(dmem_addr), .dmem_we(dmem_we),
    .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata), .mm_addr(mm_addr),
    .mm_we(mm_we), .mm_wdata(mm_wdata), .mm_rdata(mm_rdata)
  );

  always @(posedge clk) begin
    if (imem_we) imem[imem_addr] <= imem_wdata;
    imem_rdata <= imem[imem_addr];
    if (dmem_we) dmem[dmem_addr] <= dmem_wdata;
    dmem_rdata <= dmem[dmem_addr];
    if (mm_we) mmem[mm_addr[15:0]] <= mm_wdata;
    mm_rdata <= mmem[mm_addr[15:0]];
  end

  function automatic logic [7:0] pat(input int i, input logic [7:0] s);
    return 8'((i * 13) ^ (i >> 5)) ^ s;
  endfunction

  task automatic fill();
    for (int i = 0; i < 4096; i++) begin
      imem[i] = pat(i, 8'h11);
      dmem[i] = pat(i, 8'h5A);
    end
    for (int i = 0; i < 65536; i++) mmem[i] = pat(i, 8'hC3);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  // start with length write, count busy samples until done; optional mid-transfer writes
  task automatic run(input logic [1:0] len_sel, input logic [31:0] len,
                     input int inj_at, output int bcyc, output int dwidth);
    bcyc = 0; dwidth = 0;
    @(negedge clk);
    reg_we = 1'b1; reg_sel = len_sel; reg_wdata = len;
    forever begin
      @(negedge clk);
      reg_we = 1'b0;
      if (busy) bcyc++;
      if (bcyc == inj_at) begin reg_we = 1'b1; reg_sel = 2'd0; reg_wdata = 32'h1800; end
      if (bcyc == inj_at + 2 && inj_at > 0) begin reg_we = 1'b1; reg_sel = 2'd3; reg_wdata = 32'h0000_0000; end
      if (done) break;
    end
    reg_we = 1'b0;
    while (done) begin dwidth++; @(negedge clk); end
  endtask

  // mismatches for a copy, comparing destination to source with byte swizzle
  function automatic int mism(input bit out_dir, input logic [12:0] loc,
                              input logic [23:0] mn, input logic [31:0] len);
    int rb, rows, gap, bad;
    logic [11:0] li;
    logic [15:0] mi;
    logic [7:0] lv;
    rb = int'(len[11:0] | 12'd7) + 1;
    rows = int'(len[19:12]) + 1;
    gap = int'(len[31:20]);
    bad = 0;
    for (int r = 0; r < rows; r++)
      for (int b = 0; b < rb; b++) begin
        li = 12'(int'(loc[11:0]) + r * rb + b) ^ 12'd3;
        mi = 16'(int'(mn) + r * (rb + gap) + b) ^ 16'd3;
        lv = loc[12] ? imem[li] : dmem[li];
        if (lv != mmem[mi]) bad++;
      end
    return bad;
  endfunction

  task automatic t_reset();
    check(busy == 1'b0, "R11", "busy after reset", busy, 0);
    check(done == 1'b0, "R11", "done after reset", done, 0);
    check(dmem[0] == pat(0, 8'h5A) && imem[5] == pat(5, 8'h11),
          "R11", "memories untouched in reset", 0, 0);
  endtask

  task automatic t_basic_in();
    int bc, dw, bad;
    fill();
    wr(2'd0, 32'h0000_0010);
    wr(2'd1, 32'h0000_0101);
    run(2'd2, 32'h0000_0005, -1, bc, dw);
    check(bc == 16, "R1", "busy cycles for field 5 (8 bytes)", bc, 16);
    check(dw == 1, "R9", "done width", dw, 1);
    bad = mism(1'b0, 13'h0010, 24'h101, 32'h5);
    check(bad == 0, "R7", "swizzled main->local bytes (R6 code 2)", bad, 0);
    check(dmem[12'h018 ^ 12'd3] == pat(12'h018 ^ 3, 8'h5A), "R1",
          "byte after 8-byte row untouched", dmem[12'h018 ^ 12'd3], pat(12'h018 ^ 3, 8'h5A));
  endtask

  task automatic t_rows_skip();
    int bc, dw, bad, ok;
    logic [31:0] len;
    fill();
    len = {12'd5, 8'd2, 12'h009};
    wr(2'd0, 32'h0000_1200);
    wr(2'd1, 32'h0000_2003);
    run(2'd2, len, -1, bc, dw);
    check(bc == 96, "R2", "busy cycles for 3 rows of 16", bc, 96);
    bad = mism(1'b0, 13'h1200, 24'h2003, len);
    check(bad == 0, "R3", "rows gathered with skip 5", bad, 0);
    ok = 1;
    for (int i = 12'h200; i < 12'h230; i++) if (dmem[i] != pat(i, 8'h5A)) ok = 0;
    check(ok == 1, "R4", "data memory untouched when bit 12 set", ok, 1);
  endtask

  task automatic t_out();
    int bc, dw, bad, ok;
    logic [31:0] len;
    fill();
    len = {12'd3, 8'd1, 12'h007};
    wr(2'd0, 32'h0000_0040);
    wr(2'd1, 32'hFF00_3000);
    run(2'd3, len, -1, bc, dw);
    check(bc == 32, "R6", "local->main busy cycles", bc, 32);
    bad = mism(1'b1, 13'h0040, 24'h003000, len);
    check(bad == 0, "R5", "main written at masked address", bad, 0);
    ok = 1;
    for (int i = 16'h3008; i < 16'h300B; i++) if (mmem[i ^ 3] != pat(i ^ 3, 8'hC3)) ok = 0;
    check(ok == 1, "R3", "skip gap in main untouched", ok, 1);
  endtask

  task automatic t_wrap();
    int bc, dw, bad;
    fill();
    wr(2'd0, 32'h0000_0FFC);
    wr(2'd1, 32'h0000_0400);
    run(2'd2, 32'h0000_000F, -1, bc, dw);
    bad = mism(1'b0, 13'h0FFC, 24'h400, 32'hF);
    check(bad == 0, "R8", "local address wraps at 4096", bad, 0);
    check(dmem[12'h00C ^ 12'd3] == pat(12'h00C ^ 3, 8'h5A), "R8",
          "byte after wrapped run untouched", dmem[12'h00C ^ 12'd3], pat(12'h00C ^ 3, 8'h5A));
  endtask

  task automatic t_busy_ignore();
    int bc, dw, bad, ok, late;
    logic [31:0] len;
    fill();
    len = {12'd0, 8'd3, 12'h000};
    wr(2'd0, 32'h0000_0300);
    wr(2'd1, 32'h0000_0500);
    run(2'd2, len, 5, bc, dw);
    check(bc == 64, "R10", "length write while busy ignored", bc, 64);
    bad = mism(1'b0, 13'h0300, 24'h500, len);
    check(bad == 0, "R10", "address write mid-transfer has no effect", bad, 0);
    ok = 1;
    for (int i = 12'h800; i < 12'h820; i++) if (imem[i] != pat(i, 8'h11)) ok = 0;
    check(ok == 1, "R10", "imem untouched by mid-transfer address", ok, 1);
    late = 0;
    repeat (10) begin @(negedge clk); if (busy) late++; end
    check(late == 0, "R10", "no deferred transfer", late, 0);
  endtask

  task automatic t_chain();
    int bc, dw, bad;
    fill();
    wr(2'd0, 32'h0000_0600);
    wr(2'd1, 32'h0000_0700);
    run(2'd2, 32'h0000_0000, -1, bc, dw);
    // run returned at first negedge with done low; re-run and chain on done
    fill();
    @(negedge clk);
    reg_we = 1'b1; reg_sel = 2'd2; reg_wdata = 32'h0;
    @(negedge clk);
    reg_we = 1'b0;
    while (!done) @(negedge clk);
    reg_we = 1'b1; reg_sel = 2'd2; reg_wdata = 32'h0000_000F;
    @(negedge clk);
    reg_we = 1'b0;
    check(busy == 1'b1, "R10", "length write in done cycle starts", busy, 1);
    bc = 1;
    forever begin
      @(negedge clk);
      if (busy) bc++;
      if (done) break;
    end
    check(bc == 32, "R9", "chained transfer busy cycles", bc, 32);
    bad = mism(1'b0, 13'h0600, 24'h700, 32'hF);
    check(bad == 0, "R10", "chained transfer data", bad, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    fill();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic_in();
    t_rows_skip();
    t_out();
    t_wrap();
    t_busy_ignore();
    t_chain();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule